// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector Bank

A bank of general-purpose pins, each with its own 4 KiB register window on a simple 32-bit write/read bus. Every pin has a data register (synchronised input readback and the output drive bit), a configuration register (enable, polarity, detection mode, status-recording enable and a stored target field) and a status register. Inputs cross into the clock domain through a multi-stage synchroniser. Events are then detected by level or by rising, falling or any edge.

Detected events latch a per-pin status bit, which software clears by writing zero to it. The OR over all pins of the status bits gated by their enable bits drives one summary interrupt line. A handler reads the status windows of the pins it serves, runs the matching routine and clears each status bit it found set.

Top module: `gpio_irq_bank`

## Requirements
- R1: Pin n's window starts at byte address n*0x1000. Offset 0x4 holds data, 0x8 holds configuration and 0xC holds status. Any other offset, and any pin index at or above the pin count, reads as zero, and writes to them change nothing.
- R2: Data register bit 0 is read-only and returns the pin input two clock edges after it changes. Bit 1 is read/write and drives `pin_out[n]`. All other bits read zero.
- R3: Configuration bits [7:0] read back what was written, and bits [31:8] read zero. Bits [7:5] are a target field with no effect on detection.
- R4: With detection mode bits [3:2] = 00 (level), status is set on every cycle that the synchronised input equals polarity bit 1 (1 = active-high, 0 = active-low). A clear written while the level is still active is overridden.
- R5: With mode 01 (rising), a 0-to-1 input change sets status on the third clock edge after the change. A 1-to-0 change does not set it.
- R6: With mode 10 (falling), a 1-to-0 change sets status on the third edge after the change. A 0-to-1 change does not set it.
- R7: With mode 11 (both), any input change sets status, whatever the polarity bit holds.
- R8: Status is never set while configuration bit 4 (record enable) is 0.
- R9: Status bit 0 is cleared by a write whose bit 0 is 0. A write with bit 0 = 1 leaves it unchanged. When an event and a clearing write land on the same cycle, the event wins.
- R10: `irq` is the OR over all pins of (status AND configuration bit 0). A pin whose enable bit is 0 still latches status but does not raise `irq`.
- R11: After reset, all registers, `pin_out` and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W (14 by default) | Byte address; the upper bits select the pin, the low 12 bits the offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output drive values |
| irq | output | 1 | Summary interrupt |

## Verification
Some rules are checked by assertions on every cycle:
- a status bit rises only when its record-enable bit was set;
- a status bit falls only after a bus write;
- `irq` stays low while no pin is enabled;
- `pin_out` moves only after a write;
- everything is zero under reset.

Other behaviour only the bench's scenarios can show: the exact three-edge latency from pin to status, the choice of which edges count in each mode, and the priority of a persisting level over a clearing write. Randomised multi-pin traffic with random clears exposes the interplay of modes across pins.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int WIN_BITS = 12;
   localparam logic [WIN_BITS-1:0] OFS_DATA = 12'h004;
   localparam logic [WIN_BITS-1:0] OFS_CFG  = 12'h008;
   localparam logic [WIN_BITS-1:0] OFS_STAT = 12'h00C;

   typedef enum logic [1:0] {
      DET_LEVEL = 2'b00,
      DET_RISE  = 2'b01,
      DET_FALL  = 2'b10,
      DET_ANY   = 2'b11
   } det_mode_e;

   // packed MSB first: bit positions are decoded by software
   typedef struct packed {
      logic [2:0] target;  // [7:5] stored only
      logic       rec_en;  // [4]
      det_mode_e  mode;    // [3:2]
      logic       pol;     // [1]
      logic       en;      // [0]
   } pin_cfg_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] pipe;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= pipe[s-1];
         end
      end
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
   import gpio_irq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_in,
   input  logic       wr_data,
   input  logic       wr_cfg,
   input  logic       wr_stat,
   input  logic [7:0] wbyte,
   output logic       drive_q,
   output pin_cfg_t   cfg_q,
   output logic       stat_q
);

   logic prev_q;
   logic hit;
   logic evt;

   always_comb begin
      unique case (cfg_q.mode)
         DET_LEVEL: hit = (sync_in == cfg_q.pol);
         DET_RISE:  hit = sync_in & ~prev_q;
         DET_FALL:  hit = ~sync_in & prev_q;
         DET_ANY:   hit = sync_in ^ prev_q;
         default:   hit = 1'b0;
      endcase
   end

   assign evt = cfg_q.rec_en & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         drive_q <= 1'b0;
         cfg_q   <= '0;
         stat_q  <= 1'b0;
      end else begin
         prev_q <= sync_in;
         if (wr_data) drive_q <= wbyte[1];
         if (wr_cfg)  cfg_q   <= pin_cfg_t'(wbyte);
         // a new event outranks a clearing write in the same cycle
         if (evt)                      stat_q <= 1'b1;
         else if (wr_stat && !wbyte[0]) stat_q <= 1'b0;
      end
   end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_irq_pkg::*;
#(
   parameter  int NUM_PINS    = 4,
   parameter  int SYNC_STAGES = 2,
   parameter  int DATA_W      = 32,
   localparam int IDX_W       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
   localparam int ADDR_W      = IDX_W + WIN_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic                irq
);

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("gpio_irq_bank: NUM_PINS must be at least 1");
   end
   if (DATA_W != 32) begin : g_bad_width
      $error("gpio_irq_bank: DATA_W must be 32");
   end

   logic [NUM_PINS-1:0] pin_sync;
   logic [NUM_PINS-1:0] stat_v;
   logic [NUM_PINS-1:0] en_v;
   logic [NUM_PINS-1:0] rec_v;
   pin_cfg_t            cfg_a [NUM_PINS];

   logic [IDX_W-1:0]    sel_idx;
   logic [WIN_BITS-1:0] sel_ofs;
   logic                idx_ok;
   logic                unused_wdata_hi;

   assign sel_idx = bus_addr[ADDR_W-1:WIN_BITS];
   assign sel_ofs = bus_addr[WIN_BITS-1:0];
   assign idx_ok  = (int'(sel_idx) < NUM_PINS);
   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:8];

   gpio_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic hit_me;
      assign hit_me = bus_wr && idx_ok && (sel_idx == IDX_W'(i));

      gpio_pin_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .sync_in (pin_sync[i]),
         .wr_data (hit_me && (sel_ofs == OFS_DATA)),
         .wr_cfg  (hit_me && (sel_ofs == OFS_CFG)),
         .wr_stat (hit_me && (sel_ofs == OFS_STAT)),
         .wbyte   (bus_wdata[7:0]),
         .drive_q (pin_out[i]),
         .cfg_q   (cfg_a[i]),
         .stat_q  (stat_v[i])
      );

      assign en_v[i]  = cfg_a[i].en;
      assign rec_v[i] = cfg_a[i].rec_en;
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (idx_ok && (sel_idx == IDX_W'(i))) begin
            unique case (sel_ofs)
               OFS_DATA: bus_rdata[1:0] = {pin_out[i], pin_sync[i]};
               OFS_CFG:  bus_rdata[7:0] = cfg_a[i];
               OFS_STAT: bus_rdata[0]   = stat_v[i];
               default:  bus_rdata      = '0;
            endcase
         end
      end
   end

   assign irq = |(stat_v & en_v);

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
   parameter int NUM_PINS = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic                irq,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] stat_v,
   input logic [NUM_PINS-1:0] en_v,
   input logic [NUM_PINS-1:0] rec_v
);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      // R8
      stat_rise_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(stat_v[i]) |-> $past(rec_v[i]));
      // R9
      stat_fall_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(stat_v[i]) |-> $past(bus_wr));
   end

   // R10
   irq_needs_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (stat_v != '0));

   // R10
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_v == '0) |-> !irq);

   // R2
   out_moves_on_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pin_out) |-> $past(bus_wr));

   // R11
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_zero_chk: assert (!irq && pin_out == '0 && stat_v == '0);
      end
   end

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_wr  (bus_wr),
   .irq     (irq),
   .pin_out (pin_out),
   .stat_v  (stat_v),
   .en_v    (en_v),
   .rec_v   (rec_v)
);

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;

   localparam int NP = 4;
   localparam int AW = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out;
   logic          irq;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   gpio_irq_bank #(.NUM_PINS(NP)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .irq(irq)
   );

   function automatic logic [AW-1:0] addr_of(input int pin, input int ofs);
      return AW'(pin * 32'h1000 + ofs);
   endfunction

   // expected event from the requirements (R4..R7)
   function automatic logic ev_f(input logic [1:0] m, input logic p,
                                 input logic cur, input logic prv);
      case (m)
         2'b00:   return cur == p;
         2'b01:   return cur & ~prv;
         2'b10:   return ~cur & prv;
         default: return cur ^ prv;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic wr(input int pin, input int ofs, input logic [31:0] d);
      bus_addr = addr_of(pin, ofs); bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int pin, input int ofs, output logic [31:0] v);
      bus_addr = addr_of(pin, ofs); #1; v = bus_rdata;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] v;
      logic [1:0]  mode [NP];
      logic        pol [NP], rec [NP], en [NP];
      logic [NP-1:0] expst, h1, h2, h3;
      void'($urandom(32'h1234_abcd));

      repeat (3) @(negedge clk);
      // R11 reset state
      for (int p = 0; p < NP; p++) begin
         rd(p, 4, v);  chk("R11 data", v, 0);
         rd(p, 8, v);  chk("R11 cfg", v, 0);
         rd(p, 12, v); chk("R11 stat", v, 0);
      end
      chk("R11 irq/pin_out", {irq, pin_out}, 0);
      rst_n = 1'b1;
      tick(2);

      // R2 data register
      wr(1, 4, 32'h3);
      chk("R2 drive", pin_out, 4'b0010);
      rd(1, 4, v); chk("R2 readback bit0 read-only", v, 32'h2);
      pin_in[1] = 1'b1;
      tick(1); rd(1, 4, v); chk("R2 sync latency 1", v, 32'h2);
      tick(1); rd(1, 4, v); chk("R2 sync latency 2", v, 32'h3);
      wr(1, 4, 32'h0); chk("R2 drive low", pin_out, 0);
      pin_in[1] = 1'b0;

      // R3 configuration readback
      wr(2, 8, 32'hFFFF_FF00 | 32'hE0);
      rd(2, 8, v); chk("R3 cfg upper zero", v, 32'hE0);
      wr(3, 8, 32'h5A);
      rd(3, 8, v); chk("R3 cfg pin3", v, 32'h5A);
      rd(2, 8, v); chk("R1 pin2 separate window", v, 32'hE0);
      wr(2, 8, 0); wr(3, 8, 0);

      // R1 unmapped offsets
      wr(0, 0, 32'hFFFF_FFFF);
      wr(0, 16, 32'hFFFF_FFFF);
      chk("R1 ignored write pin_out", pin_out, 0);
      rd(0, 8, v); chk("R1 ignored write cfg", v, 0);
      rd(0, 0, v); chk("R1 unmapped read", v, 0);
      wr(3, 4, 32'h2); chk("R1 pin3 window", pin_out, 4'b1000);
      wr(3, 4, 32'h0);

      // R5 rising
      wr(0, 8, 32'h15);
      pin_in[0] = 1'b1;
      tick(2); rd(0, 12, v); chk("R5 not yet", v, 0);
      tick(1); rd(0, 12, v); chk("R5 rise sets", v, 1);
      chk("R10 irq up", irq, 1);
      wr(0, 12, 0); rd(0, 12, v); chk("R9 clear", v, 0);
      chk("R10 irq down", irq, 0);
      pin_in[0] = 1'b0; tick(4);
      rd(0, 12, v); chk("R5 fall ignored", v, 0);

      // R6 falling
      wr(0, 8, 32'h19);
      pin_in[0] = 1'b1; tick(4);
      rd(0, 12, v); chk("R6 rise ignored", v, 0);
      pin_in[0] = 1'b0; tick(3);
      rd(0, 12, v); chk("R6 fall sets", v, 1);
      wr(0, 12, 1); rd(0, 12, v); chk("R9 write one keeps", v, 1);
      wr(0, 12, 32'hFFFF_FFFE); rd(0, 12, v); chk("R9 write zero clears", v, 0);

      // R7 both edges, polarity 0
      wr(0, 8, 32'h1D);
      pin_in[0] = 1'b1; tick(3);
      rd(0, 12, v); chk("R7 rise", v, 1);
      wr(0, 12, 0);
      pin_in[0] = 1'b0; tick(3);
      rd(0, 12, v); chk("R7 fall", v, 1);
      wr(0, 12, 0);

      // R4 level active-high
      wr(0, 8, 32'h13);
      tick(3); rd(0, 12, v); chk("R4 inactive", v, 0);
      pin_in[0] = 1'b1; tick(3);
      rd(0, 12, v); chk("R4 high sets", v, 1);
      wr(0, 12, 0); rd(0, 12, v); chk("R4 clear overridden", v, 1);
      pin_in[0] = 1'b0; tick(3);
      wr(0, 12, 0); tick(2); rd(0, 12, v); chk("R4 clear after release", v, 0);
      // R4 active-low
      wr(0, 8, 32'h11); tick(1);
      rd(0, 12, v); chk("R4 low sets", v, 1);
      wr(0, 8, 0); wr(0, 12, 0);

      // R8 record disabled
      wr(0, 8, 32'h05);
      pin_in[0] = 1'b1; tick(4);
      rd(0, 12, v); chk("R8 no record", v, 0);
      chk("R8 irq", irq, 0);
      pin_in[0] = 1'b0; tick(2);

      // R10 masking
      wr(0, 8, 32'h14);
      pin_in[0] = 1'b1; tick(3);
      rd(0, 12, v); chk("R10 latched while masked", v, 1);
      chk("R10 masked irq", irq, 0);
      wr(0, 8, 32'h15); chk("R10 unmask", irq, 1);
      wr(0, 8, 0); wr(0, 12, 0); chk("R10 cleared", irq, 0);

      // random multi-pin phase
      pin_in = NP'($urandom);
      tick(4);
      for (int p = 0; p < NP; p++) begin
         mode[p] = 2'($urandom); pol[p] = 1'($urandom);
         rec[p] = 1'($urandom); en[p] = 1'($urandom);
         wr(p, 8, {24'b0, 3'($urandom), rec[p], mode[p], pol[p], en[p]});
      end
      tick(2);
      for (int p = 0; p < NP; p++)
         expst[p] = rec[p] && mode[p] == 2'b00 && pin_in[p] == pol[p];
      h1 = pin_in; h2 = pin_in; h3 = pin_in;
      for (int k = 0; k < 300; k++) begin
         int cp;
         logic do_clr, cb0;
         logic exp_irq;
         exp_irq = 1'b0;
         for (int p = 0; p < NP; p++) begin
            rd(p, 12, v); chk("R4-7 random status", v, {31'b0, expst[p]});
            rd(p, 4, v);  chk("R2 random sync", v[0], h2[p]);
            exp_irq |= expst[p] & en[p];
         end
         chk("R10 random irq", irq, exp_irq);
         pin_in = pin_in ^ (NP'($urandom) & NP'($urandom));
         do_clr = ($urandom % 4) == 0;
         cp = $urandom % NP;
         cb0 = 1'($urandom);
         if (do_clr) begin
            bus_addr = addr_of(cp, 12); bus_wdata = {31'($urandom), cb0}; bus_wr = 1'b1;
         end
         @(posedge clk);
         for (int p = 0; p < NP; p++) begin
            if (rec[p] && ev_f(mode[p], pol[p], h2[p], h3[p])) expst[p] = 1'b1;
            else if (do_clr && cp == p && !cb0) expst[p] = 1'b0;
         end
         h3 = h2; h2 = h1; h1 = pin_in;
         @(negedge clk);
         bus_wr = 1'b0;
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule